// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Operand Inversion

This block is the integer arithmetic and logic unit of a five-stage RISC datapath. A row of identical one-bit slices, linked by a ripple carry, does the work. Each slice can invert its A bit and its B bit. It then forms the AND, the OR and the full-adder sum of the two conditioned bits, and passes one of these or a "less" input to its output. The 4-bit operation code is not decoded into a list of cases. Its two upper bits are the two invert controls and its two lower bits are the slice output select. Subtract, set-on-less-than and NOR therefore come out of the same slice hardware as AND, OR and add.

The result, a zero flag and a signed-overflow flag are registered on the rising clock edge. Each result appears one cycle after its operands and code are presented. Codes outside the six defined operations produce a result of zero.

Top module: `slice_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs load `result_o` = 0, `zero_o` = 1 and `ovf_o` = 0.
- R2: Code 4'b0000 gives `a_i & b_i`, and code 4'b0001 gives `a_i | b_i`.
- R3: Code 4'b0010 gives `a_i + b_i` modulo 2^32. `ovf_o` is 1 exactly when both operands have the same sign and the sum has the other sign, which is when the carry into bit 31 differs from the carry out of bit 31.
- R4: Code 4'b0110 gives `a_i - b_i` modulo 2^32, formed as A + ~B + 1. `ovf_o` is 1 exactly when the operands differ in sign and the difference has a sign different from A.
- R5: Code 4'b0111 gives a result whose bits 31..1 are 0 and whose bit 0 equals bit 31 of the 32-bit difference `a_i - b_i`. This is the raw sign of the wrapped difference, so it is not corrected when the subtraction overflows.
- R6: Code 4'b1100 gives `~(a_i | b_i)`, formed as the AND of the two inverted operands.
- R7: The ten codes other than 0000, 0001, 0010, 0110, 0111 and 1100 give `result_o` = 0 and `ovf_o` = 0.
- R8: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0.
- R9: `ovf_o` is 0 for every code except 0010 and 0110.
- R10: The outputs for the code and operands present at rising edge N are visible from edge N until edge N+1, so results come one cycle after the inputs, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code: [3] inverts A, [2] inverts B and sets the carry in, [1:0] selects the slice output |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered flag, 1 when the result is zero |
| ovf_o | output | 1 | Registered signed-overflow flag for add and subtract |

## Verification
The hardest case to reach is set-on-less-than when the subtraction overflows. Here the raw sign bit disagrees with a true signed comparison, and random operands rarely land on it. The stimulus therefore pairs the extreme values 0x80000000, 0x7FFFFFFF, 0, 1 and all-ones with one another under every one of the sixteen codes. The wrap points of add, subtract and set-on-less-than are all covered this way. Pseudo-random operands then cover carry chains of mixed length. Every illegal code is also sent with operands whose AND, OR and sum are all nonzero, so a code that leaks through shows up at `result_o`.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_OR  = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0010;
  localparam logic [3:0] OP_SUB = 4'b0110;
  localparam logic [3:0] OP_SLT = 4'b0111;
  localparam logic [3:0] OP_NOR = 4'b1100;

  localparam logic [1:0] SEL_AND  = 2'b00;
  localparam logic [1:0] SEL_OR   = 2'b01;
  localparam logic [1:0] SEL_SUM  = 2'b10;
  localparam logic [1:0] SEL_LESS = 2'b11;

  typedef struct packed {
    logic       legal;
    logic       inv_a;
    logic       inv_b;
    logic [1:0] sel;
    logic       arith;
  } ctl_t;

  function automatic logic op_is_legal(input logic [3:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_ADD) ||
           (op == OP_SUB) || (op == OP_SLT) || (op == OP_NOR);
  endfunction
endpackage

// File: rtl/slice_alu_decode.sv
module slice_alu_decode
  import slice_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output ctl_t       ctl_o
);
  always_comb begin
    ctl_o.legal = op_is_legal(op_i);
    ctl_o.inv_a = op_i[3];
    ctl_o.inv_b = op_i[2];
    ctl_o.sel   = op_i[1:0];
    ctl_o.arith = op_is_legal(op_i) && (op_i[1:0] == SEL_SUM);
  end
endmodule

// File: rtl/slice_alu_bit.sv
module slice_alu_bit
  import slice_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       cin_i,
  input  logic       less_i,
  input  logic       inv_a_i,
  input  logic       inv_b_i,
  input  logic [1:0] sel_i,
  output logic       res_o,
  output logic       cout_o
);
  logic ax, bx, s;

  always_comb begin
    ax     = a_i ^ inv_a_i;
    bx     = b_i ^ inv_b_i;
    s      = ax ^ bx ^ cin_i;
    cout_o = (ax & bx) | (cin_i & (ax ^ bx));
    unique case (sel_i)
      SEL_AND: res_o = ax & bx;
      SEL_OR:  res_o = ax | bx;
      SEL_SUM: res_o = s;
      default: res_o = less_i;
    endcase
  end
endmodule

// File: rtl/slice_alu_ripple.sv
module slice_alu_ripple
  import slice_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  ctl_t         ctl_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W:0]   carry;
  logic [W-1:0] less;
  logic         top_sum;

  assign carry[0] = ctl_i.inv_b;

  // sign bit of the conditioned sum feeds bit 0 for set-on-less-than
  assign top_sum = (a_i[MSB] ^ ctl_i.inv_a) ^ (b_i[MSB] ^ ctl_i.inv_b) ^ carry[MSB];

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      if (i == 0) begin : g_lsb
        assign less[i] = top_sum;
      end else begin : g_upper
        assign less[i] = 1'b0;
      end
      slice_alu_bit u_bit (
        .a_i     (a_i[i]),
        .b_i     (b_i[i]),
        .cin_i   (carry[i]),
        .less_i  (less[i]),
        .inv_a_i (ctl_i.inv_a),
        .inv_b_i (ctl_i.inv_b),
        .sel_i   (ctl_i.sel),
        .res_o   (res_o[i]),
        .cout_o  (carry[i+1])
      );
    end
  endgenerate

  assign ovf_o = carry[MSB] ^ carry[W];
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         ovf_o
);
  ctl_t         ctl;
  logic [W-1:0] raw_res;
  logic         raw_ovf;
  logic [W-1:0] nxt_res;
  logic         nxt_ovf;

  slice_alu_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  slice_alu_ripple #(.W(W)) u_rip (
    .a_i   (a_i),
    .b_i   (b_i),
    .ctl_i (ctl),
    .res_o (raw_res),
    .ovf_o (raw_ovf)
  );

  always_comb begin
    nxt_res = ctl.legal ? raw_res : '0;
    nxt_ovf = ctl.arith & raw_ovf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      zero_o   <= 1'b1;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= nxt_res;
      zero_o   <= (nxt_res == '0);
      ovf_o    <= nxt_ovf;
    end
  end
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk
  import slice_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         ovf_o
);
  logic         pv;
  logic [3:0]   pop;
  logic [W-1:0] pa, pb;

  always_ff @(posedge clk) begin
    pv  <= !rst;
    pop <= op_i;
    pa  <= a_i;
    pb  <= b_i;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (result_o == '0 && zero_o && !ovf_o));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
    pv |-> (zero_o == (result_o == '0)));

  p_and_r2: assert property (@(posedge clk) disable iff (rst)
    (pv && pop == OP_AND) |-> (result_o == (pa & pb)));

  p_nor_r6: assert property (@(posedge clk) disable iff (rst)
    (pv && pop == OP_NOR) |-> (result_o == ~(pa | pb)));

  p_slt_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (pv && pop == OP_SLT) |-> (result_o[W-1:1] == '0));

  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (pv && !op_is_legal(pop)) |-> (result_o == '0 && !ovf_o));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    (pv && pop != OP_ADD && pop != OP_SUB) |-> !ovf_o);
endmodule

bind slice_alu slice_alu_chk #(.W(W)) chk_i (.*);

// File: tb/slice_alu_tb_top.sv
module slice_alu_tb_top;
  localparam int W = 32;

  typedef struct {
    logic [3:0]   op;
    logic [W-1:0] res;
    logic         z;
    logic         v;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o;
  logic         zero_o, ovf_o;

  int   applied = 0;
  int   miscompares = 0;
  bit   done = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  slice_alu #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .zero_o(zero_o), .ovf_o(ovf_o)
  );

  function automatic exp_t model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    logic [W-1:0] s, d;
    s = a + b;
    d = a - b;
    e.op = op;
    e.v  = 1'b0;
    case (op)
      4'b0000: e.res = a & b;
      4'b0001: e.res = a | b;
      4'b0010: begin e.res = s; e.v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]); end
      4'b0110: begin e.res = d; e.v = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]); end
      4'b0111: e.res = {{(W-1){1'b0}}, d[W-1]};
      4'b1100: e.res = ~(a | b);
      default: e.res = '0;
    endcase
    e.z = (e.res == '0);
    return e;
  endfunction

  function automatic string tag(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b;
    q.push_back(model(op, a, b));
  endtask

  // monitor: output for inputs driven at a negedge is checked 1 ns after the next rising edge (R10)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        applied++;
        if (result_o !== e.res) begin
          miscompares++;
          $display("FAIL %s R10 op=%b result actual=%h expected=%h", tag(e.op), e.op, result_o, e.res);
        end
        if (zero_o !== e.z) begin
          miscompares++;
          $display("FAIL R8 op=%b zero actual=%b expected=%b", e.op, zero_o, e.z);
        end
        if (ovf_o !== e.v) begin
          miscompares++;
          $display("FAIL %s R9 op=%b ovf actual=%b expected=%b", tag(e.op), e.op, ovf_o, e.v);
        end
      end
    end
  end

  logic [W-1:0] edges [5] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF};

  initial begin
    logic [W-1:0] lfsr;
    lfsr = 32'hACE1_1234;
    repeat (3) @(posedge clk);
    #1;
    applied++;
    if (result_o !== '0 || zero_o !== 1'b1 || ovf_o !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset actual=%h/%b/%b expected=0/1/0", result_o, zero_o, ovf_o);
    end
    @(negedge clk);
    rst = 1'b0;
    // directed signed corners under every code (R3 R4 R5 overflow corners)
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(o[3:0], edges[i], edges[j]);
    // R7: illegal codes with operands whose AND, OR and sum are nonzero
    for (int o = 0; o < 16; o++)
      drive(o[3:0], 32'hF0F0_F0F3, 32'h0FF0_0F01);
    // pseudo-random operands for all codes
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = (k % 7 == 0) ? ra : lfsr;
      drive(k[3:0], ra, rb);
    end
    // R1: reset in mid-stream clears the outputs on the next edge
    drive(4'b0001, 32'h1234_5678, 32'h0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    applied++;
    if (result_o !== '0 || zero_o !== 1'b1 || ovf_o !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 mid reset actual=%h/%b/%b expected=0/1/0", result_o, zero_o, ovf_o);
    end
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule